// File: doc/BRIEF.md
# SPI Memory Slave Serial Front-End with Pause

This block is the serial edge of an SPI memory slave. It oversamples the select, clock, data-in and pause pins in the system clock domain. An active-low select frames each transaction. Bits on the data-in line are captured on rising serial-clock edges, most significant bit first, in SPI mode 0. After every eighth captured bit, the block hands a whole byte to a downstream command decoder with a one-cycle strobe. It also marks the start and end of each frame with one-cycle strobes.

Read data comes from the decoder on `tx_data_i`. It is loaded when a frame begins and again after every complete byte. The block shifts it out on falling serial-clock edges, with a separate output-enable that stands for the high-impedance state. When the decoder holds `wr_arm_i` high and the frame closes on a byte boundary, the block raises a single-cycle write trigger so that the internal write can begin.

An active-low pause input freezes a transaction part-way through. The pause takes hold, and lets go, only while the serial clock is low. While paused, the output is disabled and the data-in line has no effect. When the pause ends, the transaction carries on from the same bit.

Top module: `spi_slave_frontend`

## Requirements
- R1: After synchronous reset, `so_oe_o`, `rx_valid_o`, `frame_start_o`, `frame_end_o` and `write_go_o` are 0, and `standby_o` is 1.
- R2: Bits on `si_i` are captured on rising `sck_i` edges, most significant first. After each eighth captured bit of a frame, `rx_byte_o` holds the byte and `rx_valid_o` pulses for one cycle.
- R3: The first output bit is `tx_data_i[7]`, loaded at the select's falling edge. Each falling `sck_i` edge moves `so_o` to the next lower bit. The falling edge after a byte's eighth rising edge loads a fresh `tx_data_i`.
- R4: While `cs_n_i` is high, `so_oe_o` is 0.
- R5: Each falling edge of `cs_n_i` gives one `frame_start_o` pulse, and each rising edge gives one `frame_end_o` pulse.
- R6: A falling edge of `cs_n_i` clears the bit counter. A partial byte at frame end produces no `rx_valid_o` pulse and does not shift the bits of the next frame.
- R7: `write_go_o` pulses once, at frame end, when `wr_arm_i` is 1 and the frame ended on a byte boundary.
- R8: `write_go_o` stays 0 when the frame ends with a partial byte, even with `wr_arm_i` at 1.
- R9: When `hold_n_i` goes low while `sck_i` is low, the block pauses. `so_oe_o` goes to 0 and changes on `si_i` are ignored. Releasing `hold_n_i` while `sck_i` is low resumes the transaction at the same bit.
- R10: A change of `hold_n_i` while `sck_i` is high has no effect until `sck_i` next goes low.
- R11: `standby_o` is 1 exactly when `cs_n_i` is high and `write_busy_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low select pin |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low pause pin |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for serial data out (0 = high impedance) |
| tx_data_i | input | 8 | Next byte to transmit, from the decoder |
| rx_byte_o | output | 8 | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe, new byte on rx_byte_o |
| frame_start_o | output | 1 | One-cycle strobe at select assertion |
| frame_end_o | output | 1 | One-cycle strobe at select release |
| wr_arm_i | input | 1 | Decoder flags a valid write sequence |
| write_busy_i | input | 1 | Internal write cycle still running |
| write_go_o | output | 1 | One-cycle trigger to start the internal write |
| standby_o | output | 1 | Slave idle and in standby |

## Verification
Bytes of alternating, all-ones, all-zeros and mixed patterns are sent in single-byte and multi-byte frames. A bit-order or counter fault therefore shows up as a byte mismatch, and a reload fault shows up as a wrong output bit at a byte boundary. A frame cut after three bits, followed by a full frame, separates a stale-counter fault from a correct discard, and checks that no write trigger is raised for a partial byte. Two pauses are tried. In one, the pause pin drops while the clock is low and the data-in line toggles during the pause. In the other, it drops while the clock is high. Comparing the two tells apart a pause that is properly gated by the clock phase from one that acts at once.

// File: rtl/sfe_pkg.sv
// Package: shared sizes and types for the serial front-end.
// Assumes byte-wide serial transfers.
package sfe_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;
endpackage

// File: rtl/sfe_sync.sv
// Module: multi-bit pin synchronizer, one independent flop chain per bit.
// Assumes each bit is an unrelated asynchronous level; RST_VAL gives idle levels.
module sfe_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/sfe_hold_ctrl.sv
// Module: pause state tracker. It enters or leaves the pause only while the
// synchronized serial clock is low, and clears when the select is released.
// Assumes synchronized inputs.
module sfe_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act_i,
    input  logic sck_s_i,
    input  logic hold_n_s_i,
    output logic held_o
);
    // Follow the pause pin only during the clock-low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)          held_o <= 1'b0;
        else if (!cs_act_i)  held_o <= 1'b0;
        else if (!sck_s_i)   held_o <= !hold_n_s_i;
    end

    AST_HOLD_ENTER_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_o) |-> $past(!sck_s_i)); // R10
    AST_HOLD_LEAVE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(held_o) && $past(cs_act_i)) |-> $past(!sck_s_i)); // R9
endmodule

// File: rtl/sfe_shifter.sv
// Module: receive and transmit shift datapath plus the frame strobes.
// Assumes the edge inputs are single-cycle pulses that are already gated by
// select and pause.
module sfe_shifter
    import sfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_fall_i,
    input  logic  cs_rise_i,
    input  logic  sck_rise_i,
    input  logic  sck_fall_i,
    input  logic  si_i,
    input  byte_t tx_data_i,
    input  logic  wr_arm_i,
    output byte_t rx_byte_o,
    output logic  rx_valid_o,
    output logic  frame_start_o,
    output logic  frame_end_o,
    output logic  write_go_o,
    output logic  so_bit_o
);
    localparam bitcnt_t LAST = bitcnt_t'(BYTE_W - 1);

    byte_t   rx_sh;
    byte_t   tx_sh;
    bitcnt_t cnt;

    // Frame framing, bit capture on rising edges, bit launch on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0; tx_sh <= '0; cnt <= '0; rx_byte_o <= '0;
            rx_valid_o <= 1'b0; frame_start_o <= 1'b0;
            frame_end_o <= 1'b0; write_go_o <= 1'b0;
        end else begin
            rx_valid_o    <= 1'b0;
            frame_start_o <= 1'b0;
            frame_end_o   <= 1'b0;
            write_go_o    <= 1'b0;
            if (cs_fall_i) begin
                cnt           <= '0;
                rx_sh         <= '0;
                tx_sh         <= tx_data_i;
                frame_start_o <= 1'b1;
            end else if (cs_rise_i) begin
                frame_end_o <= 1'b1;
                write_go_o  <= wr_arm_i && (cnt == '0);
                cnt         <= '0;
            end else begin
                if (sck_rise_i) begin
                    rx_sh <= {rx_sh[BYTE_W-2:0], si_i};
                    if (cnt == LAST) begin
                        cnt        <= '0;
                        rx_byte_o  <= {rx_sh[BYTE_W-2:0], si_i};
                        rx_valid_o <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (sck_fall_i) begin
                    if (cnt == '0) tx_sh <= tx_data_i;
                    else           tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign so_bit_o = tx_sh[BYTE_W-1];

    AST_BYTE_ON_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> ($past(cnt) == LAST && $past(sck_rise_i))); // R2
    AST_START_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (cnt == '0)); // R6
    AST_GO_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        write_go_o |-> frame_end_o); // R7
endmodule

// File: rtl/spi_slave_frontend.sv
// Module: top of the SPI slave front-end. It synchronizes the pins, finds
// the select and clock edges, gates them by the pause state and drives the
// datapath. Assumes the serial clock is well below the system clock (each
// phase lasts several system cycles).
module spi_slave_frontend
    import sfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n_i,
    input  logic        sck_i,
    input  logic        si_i,
    input  logic        hold_n_i,
    output logic        so_o,
    output logic        so_oe_o,
    input  logic [7:0]  tx_data_i,
    output logic [7:0]  rx_byte_o,
    output logic        rx_valid_o,
    output logic        frame_start_o,
    output logic        frame_end_o,
    input  logic        wr_arm_i,
    input  logic        write_busy_i,
    output logic        write_go_o,
    output logic        standby_o
);
    logic [3:0] pins_s;
    logic cs_n_s, sck_s, si_s, hold_n_s;
    logic cs_n_q, sck_q, held;
    logic cs_act, cs_fall, cs_rise, sck_rise, sck_fall;

    sfe_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({cs_n_i, sck_i, si_i, hold_n_i}),
        .q_o(pins_s)
    );
    assign {cs_n_s, sck_s, si_s, hold_n_s} = pins_s;

    // Keep the previous synchronized select and clock levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            sck_q  <= 1'b0;
        end else begin
            cs_n_q <= cs_n_s;
            sck_q  <= sck_s;
        end
    end

    assign cs_act   = !cs_n_s;
    assign cs_fall  = cs_n_q && !cs_n_s;
    assign cs_rise  = !cs_n_q && cs_n_s;
    assign sck_rise = cs_act && !held && sck_s && !sck_q;
    assign sck_fall = cs_act && !held && !sck_s && sck_q;

    sfe_hold_ctrl u_hold (
        .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act),
        .sck_s_i(sck_s), .hold_n_s_i(hold_n_s), .held_o(held)
    );

    sfe_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
        .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
        .si_i(si_s), .tx_data_i(tx_data_i), .wr_arm_i(wr_arm_i),
        .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
        .frame_start_o(frame_start_o), .frame_end_o(frame_end_o),
        .write_go_o(write_go_o), .so_bit_o(so_o)
    );

    assign so_oe_o   = cs_act && !held;
    assign standby_o = cs_n_s && !write_busy_i;

    AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !so_oe_o); // R4
    AST_NO_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> !rx_valid_o); // R9
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !so_oe_o); // R11
endmodule

// File: tb/spi_slave_frontend_bench.sv
module spi_slave_frontend_bench;
    localparam int P = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       wr_arm = 1'b0, write_busy = 1'b0;
    logic       so, so_oe, rx_valid, fstart, fend, wgo, standby;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0;
    int n_rx = 0, n_fs = 0, n_fe = 0, n_wg = 0;
    logic [7:0] exp_q[$];
    bit done = 0;

    always #2 clk = ~clk;

    spi_slave_frontend u_spi_slave_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
        .hold_n_i(hold_n), .so_o(so), .so_oe_o(so_oe), .tx_data_i(tx_data),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .frame_start_o(fstart),
        .frame_end_o(fend), .wr_arm_i(wr_arm), .write_busy_i(write_busy),
        .write_go_o(wgo), .standby_o(standby)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: count strobes and compare received bytes with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fstart) n_fs++;
            if (fend)   n_fe++;
            if (wgo)    n_wg++;
            if (rx_valid) begin
                n_rx++;
                if (exp_q.size() == 0) check("R2 unexpected byte", {24'h0, rx_byte}, 32'hFFFF_FFFF);
                else check("R2 received byte", {24'h0, rx_byte}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic wait_p(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low(input logic [7:0] first_tx);
        tx_data = first_tx;
        wait_p(P);
        cs_n = 1'b0;
        wait_p(P);
    endtask

    task automatic cs_high();
        sck = 1'b0;
        wait_p(P);
        cs_n = 1'b1;
        wait_p(P);
    endtask

    // Driver: one byte. hold_at >= 0 pauses before that bit.
    // hold_hi = 1 drops the pause pin while the clock is high.
    task automatic xfer(input logic [7:0] mosi, input logic [7:0] miso,
                        input logic [7:0] next_tx, input int hold_at, input bit hold_hi);
        exp_q.push_back(mosi);
        for (int i = 0; i < 8; i++) begin
            if (i == hold_at && !hold_hi) begin
                hold_n = 1'b0; wait_p(P);
                check("R9 output disabled in pause", {31'h0, so_oe}, 32'h0);
                for (int k = 0; k < 4; k++) begin si = ~si; wait_p(3); end
                hold_n = 1'b1; wait_p(P);
                check("R9 output back after pause", {31'h0, so_oe}, 32'h1);
            end
            si = mosi[7-i];
            wait_p(P);
            check("R3 output bit", {31'h0, so}, {31'h0, miso[7-i]});
            sck = 1'b1;
            if (i == 7) tx_data = next_tx;
            wait_p(P);
            if (i == hold_at && hold_hi) begin
                hold_n = 1'b0; wait_p(P);
                check("R10 pause ignored while clock high", {31'h0, so_oe}, 32'h1);
                sck = 1'b0; wait_p(P);
                check("R10 pause taken at clock low", {31'h0, so_oe}, 32'h0);
                for (int k = 0; k < 4; k++) begin si = ~si; wait_p(3); end
                hold_n = 1'b1; wait_p(P);
                check("R10 output back after pause", {31'h0, so_oe}, 32'h1);
            end else begin
                sck = 1'b0;
            end
        end
    endtask

    initial begin
        wait_p(5);
        rst_n = 1'b1;
        wait_p(1);
        // R1 reset state
        check("R1 oe", {31'h0, so_oe}, 32'h0);
        check("R1 rx_valid", {31'h0, rx_valid}, 32'h0);
        check("R1 write_go", {31'h0, wgo}, 32'h0);
        check("R1 standby", {31'h0, standby}, 32'h1);

        // Multi-byte frame with several patterns: R2, R3, R5
        cs_low(8'h96);
        check("R4 output enabled when selected", {31'h0, so_oe}, 32'h1);
        check("R11 not standby when selected", {31'h0, standby}, 32'h0);
        xfer(8'hA5, 8'h96, 8'h0F, -1, 0);
        xfer(8'hFF, 8'h0F, 8'hC3, -1, 0);
        xfer(8'h00, 8'hC3, 8'h00, -1, 0);
        xfer(8'h3C, 8'h00, 8'h00, -1, 0);
        cs_high();
        check("R4 output off when deselected", {31'h0, so_oe}, 32'h0);
        check("R5 frame starts", n_fs, 1);
        check("R5 frame ends", n_fe, 1);
        check("R2 byte count", n_rx, 4);
        check("R7 no write without arm", n_wg, 0);

        // Partial byte then full frame: R6, R8
        wr_arm = 1'b1;
        cs_low(8'h00);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; wait_p(P); sck = 1'b1; wait_p(P); sck = 1'b0;
        end
        cs_high();
        check("R6 partial byte dropped", n_rx, 4);
        check("R8 no write after partial byte", n_wg, 0);
        cs_low(8'h5A);
        xfer(8'h81, 8'h5A, 8'h00, -1, 0);
        cs_high();
        check("R6 counter restarted", n_rx, 5);
        check("R7 write trigger", n_wg, 1);
        wr_arm = 1'b0;

        // Pause while clock low: R9
        cs_low(8'hB4);
        xfer(8'h6D, 8'hB4, 8'h00, 4, 0);
        cs_high();
        // Pause pin changed while clock high: R10
        cs_low(8'h2E);
        xfer(8'hE2, 8'h2E, 8'h00, 2, 1);
        cs_high();
        check("R9 bytes after pauses", n_rx, 7);

        // Standby with internal write running: R11
        write_busy = 1'b1; wait_p(P);
        check("R11 standby blocked by busy write", {31'h0, standby}, 32'h0);
        write_busy = 1'b0; wait_p(P);
        check("R11 standby when idle", {31'h0, standby}, 32'h1);

        check("R2 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule